// File: doc/BRIEF.md
# Unipolar Stepper Phase Sequencer

This block turns a stream of step pulses into the four winding enables of a two-phase unipolar stepper motor. Each phase has two windings. The block moves through an eight-position cycle. Even positions energise one winding of each phase. Odd positions energise one phase only and leave the other phase fully off. A half-step select input chooses between single-position and two-position moves. A direction input chooses which way the cycle is walked.

Beside the winding enables, the block reports two kinds of status. Each phase has a flag that marks a position where that phase's current is deliberately off. An outside controller can read these flags to tell when changing from half-step to full-step operation keeps the position intact. Each phase also has a one-cycle kick pulse, raised when that phase switches a winding on. The kick restarts an external high-voltage boost timer.

Step, direction and half-step select all pass through the same clock-domain synchroniser. Direction and half-step select are therefore taken as they stood at the falling step edge. An inhibit input turns all windings off without losing the position. The synchronous reset returns the block to its home position.

Top module: `stepper_seq`

## Requirements
- R1: Each falling edge of `step_in` moves the position exactly once, provided `inhibit` is low. A rising edge never moves it. The windings take their new value no later than the fourth rising clock edge after `step_in` is first sampled low.
- R2: `dir_in` and `half_n_in` are only used as they stand at a falling step edge. Changing either of them with no step edge leaves the windings, the zero flags and the kick outputs unchanged.
- R3: With `half_n_in` low, a step moves one position. With `half_n_in` high and the position even, a step moves two positions. Positions wrap modulo 8.
- R4: With `half_n_in` high and the position odd, a step moves one position, onto the neighbouring even position in the commanded direction.
- R5: `dir_in` high walks the positions upward and `dir_in` low walks them downward. Positions 0 to 7 drive {a_win1,a_win2,b_win1,b_win2} as follows: 1010, 0010, 0110, 0100, 0101, 0001, 1001, 1000.
- R6: While `inhibit` is high, all four winding outputs are low from the next clock edge on. Step edges are ignored. The position is kept, so the windings show its pattern again after release.
- R7: While `rst` is high, all outputs are low and the position returns to 0. After release the windings show 1010.
- R8: `a_zero` is high exactly at positions 1 and 5, where both A windings are off. `b_zero` is high exactly at positions 3 and 7. The flags follow the position even while inhibited.
- R9: `a_kick` (`b_kick`) is high for one cycle, in the cycle where the delivered A (B) winding pair takes a new value that has a winding on. It is never high otherwise.
- R10: `a_win1` and `a_win2` are never high together. `b_win1` and `b_win2` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| step_in | input | 1 | Step pulse; falling edge advances |
| dir_in | input | 1 | Direction: 1 up, 0 down |
| half_n_in | input | 1 | Low selects half-step moves |
| inhibit | input | 1 | High forces all windings off |
| a_win1 | output | 1 | Phase A winding 1 enable |
| a_win2 | output | 1 | Phase A winding 2 enable |
| b_win1 | output | 1 | Phase B winding 1 enable |
| b_win2 | output | 1 | Phase B winding 2 enable |
| a_zero | output | 1 | Phase A at zero-current half position |
| b_zero | output | 1 | Phase B at zero-current half position |
| a_kick | output | 1 | One-cycle boost retrigger, phase A |
| b_kick | output | 1 | One-cycle boost retrigger, phase B |

## Verification
The hardest case to reach is a full-step command issued while the position is odd. From reset the position is even, and full-step pulses keep it even. The stimulus therefore first takes a half step to land on an odd position. It then raises the half-step select only between pulses and issues a full-step pulse in each direction. A step taken while inhibited is also hard to observe, because every winding is dark. Its absence is shown after release: the windings reappear with the old pattern, and the next normal step moves from the retained position.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;
  localparam int POS_W   = 3;
  localparam int NUM_POS = 1 << POS_W;

  typedef logic [POS_W-1:0] pos_t;

  // a/b: {winding1, winding2} of each phase
  typedef struct packed {
    logic [1:0] a;
    logic [1:0] b;
  } drive_t;

  function automatic drive_t pos_decode(input pos_t p);
    drive_t d;
    case (p)
      3'd0:    d = '{a: 2'b10, b: 2'b10};
      3'd1:    d = '{a: 2'b00, b: 2'b10};
      3'd2:    d = '{a: 2'b01, b: 2'b10};
      3'd3:    d = '{a: 2'b01, b: 2'b00};
      3'd4:    d = '{a: 2'b01, b: 2'b01};
      3'd5:    d = '{a: 2'b00, b: 2'b01};
      3'd6:    d = '{a: 2'b10, b: 2'b01};
      default: d = '{a: 2'b10, b: 2'b00};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/step_edge.sv
module step_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step_in,
  input  logic dir_in,
  input  logic half_n_in,
  output logic fall,
  output logic dir_s,
  output logic half_n_s
);
  localparam int LAST = SYNC_STAGES - 1;

  // bit 2 step, bit 1 dir, bit 0 half_n; all share one delay so they stay aligned
  logic [2:0] chain [SYNC_STAGES];
  logic       step_prev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '1;
          else     chain[0] <= {step_in, dir_in, half_n_in};
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) step_prev <= 1'b1;
    else     step_prev <= chain[LAST][2];
  end

  assign fall     = step_prev & ~chain[LAST][2];
  assign dir_s    = chain[LAST][1];
  assign half_n_s = chain[LAST][0];

  // an edge is seen in one cycle only
  assert_single_edge_R1: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/seq_position.sv
module seq_position
  import stepper_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fall,
  input  logic dir_s,
  input  logic half_n_s,
  input  logic inhibit,
  output pos_t pos_q
);
  pos_t amt;
  pos_t pos_d;

  always_comb begin
    amt   = (half_n_s && !pos_q[0]) ? pos_t'(2) : pos_t'(1);
    pos_d = pos_q;
    if (fall && !inhibit) pos_d = dir_s ? pos_q + amt : pos_q - amt;
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_d;
  end

  assert_hold_pos_R6: assert property (@(posedge clk) disable iff (rst)
    (!fall || inhibit) |=> $stable(pos_q));
  assert_moves_R1: assert property (@(posedge clk) disable iff (rst)
    (fall && !inhibit) |=> (pos_q != $past(pos_q)));
  assert_full_even_R3: assert property (@(posedge clk) disable iff (rst)
    (fall && !inhibit && half_n_s && !pos_q[0]) |=> !pos_q[0]);
  assert_full_odd_R4: assert property (@(posedge clk) disable iff (rst)
    (fall && !inhibit && half_n_s && pos_q[0]) |=> !pos_q[0]);
endmodule

// File: rtl/drive_stage.sv
module drive_stage
  import stepper_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   inhibit,
  input  pos_t   pos_q,
  output drive_t drv_q,
  output logic   zero_a,
  output logic   zero_b,
  output logic   kick_a,
  output logic   kick_b
);
  drive_t tab;
  drive_t drv_d;

  always_comb begin
    tab   = pos_decode(pos_q);
    drv_d = inhibit ? '0 : tab;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= '0;
      zero_a <= 1'b0;
      zero_b <= 1'b0;
      kick_a <= 1'b0;
      kick_b <= 1'b0;
    end else begin
      drv_q  <= drv_d;
      zero_a <= (tab.a == 2'b00);
      zero_b <= (tab.b == 2'b00);
      kick_a <= (drv_d.a != drv_q.a) && (drv_d.a != 2'b00);
      kick_b <= (drv_d.b != drv_q.b) && (drv_d.b != 2'b00);
    end
  end

  assert_reset_off_R7: assert property (@(posedge clk)
    rst |=> (drv_q == '0 && !kick_a && !kick_b && !zero_a && !zero_b));
  assert_inhibit_off_R6: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (drv_q == '0));
  assert_zero_dark_R8: assert property (@(posedge clk) disable iff (rst)
    (zero_a |-> drv_q.a == 2'b00) and (zero_b |-> drv_q.b == 2'b00));
  assert_kick_on_R9: assert property (@(posedge clk) disable iff (rst)
    (kick_a |-> drv_q.a != 2'b00) and (kick_b |-> drv_q.b != 2'b00));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    (drv_q.a != 2'b11) && (drv_q.b != 2'b11));
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step_in,
  input  logic dir_in,
  input  logic half_n_in,
  input  logic inhibit,
  output logic a_win1,
  output logic a_win2,
  output logic b_win1,
  output logic b_win2,
  output logic a_zero,
  output logic b_zero,
  output logic a_kick,
  output logic b_kick
);
  logic   fall, dir_s, half_n_s;
  pos_t   pos_q;
  drive_t drv_q;

  step_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
    .half_n_in(half_n_in), .fall(fall), .dir_s(dir_s), .half_n_s(half_n_s)
  );

  seq_position u_pos (
    .clk(clk), .rst(rst), .fall(fall), .dir_s(dir_s),
    .half_n_s(half_n_s), .inhibit(inhibit), .pos_q(pos_q)
  );

  drive_stage u_drive (
    .clk(clk), .rst(rst), .inhibit(inhibit), .pos_q(pos_q), .drv_q(drv_q),
    .zero_a(a_zero), .zero_b(b_zero), .kick_a(a_kick), .kick_b(b_kick)
  );

  assign {a_win1, a_win2} = drv_q.a;
  assign {b_win1, b_win2} = drv_q.b;
endmodule

// File: tb/stepper_seq_bench.sv
module stepper_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, step_in = 1'b1, dir_in = 1'b1;
  logic half_n_in = 1'b1, inhibit = 1'b0;
  logic a_win1, a_win2, b_win1, b_win2, a_zero, b_zero, a_kick, b_kick;

  int checks = 0, errors = 0, exp_pos = 0;
  int kick_a_cnt = 0, kick_b_cnt = 0;

  stepper_seq u_stepper_seq (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
    .half_n_in(half_n_in), .inhibit(inhibit),
    .a_win1(a_win1), .a_win2(a_win2), .b_win1(b_win1), .b_win2(b_win2),
    .a_zero(a_zero), .b_zero(b_zero), .a_kick(a_kick), .b_kick(b_kick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (a_kick === 1'b1) kick_a_cnt++;
    if (b_kick === 1'b1) kick_b_cnt++;
  end

  // R5 table: {a_win1,a_win2,b_win1,b_win2}
  function automatic logic [3:0] pattern(input int p);
    case (p)
      0: return 4'b1010;
      1: return 4'b0010;
      2: return 4'b0110;
      3: return 4'b0100;
      4: return 4'b0101;
      5: return 4'b0001;
      6: return 4'b1001;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [3:0] delivered(input logic inh, input int p);
    return inh ? 4'b0000 : pattern(p);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check({tag, " R5 windings"}, int'({a_win1, a_win2, b_win1, b_win2}),
          int'(delivered(inhibit, exp_pos)));
    check({tag, " R8 zero flags"}, int'({a_zero, b_zero}),
          int'({exp_pos == 1 || exp_pos == 5, exp_pos == 3 || exp_pos == 7}));
    check({tag, " R10 exclusive"},
          int'((a_win1 & a_win2) | (b_win1 & b_win2)), 0);
  endtask

  task automatic do_step(input string tag, input logic d, input logic h);
    logic [3:0] old_d, new_d;
    int a0, b0, amt;
    old_d = delivered(inhibit, exp_pos);
    a0 = kick_a_cnt; b0 = kick_b_cnt;
    @(negedge clk); dir_in = d; half_n_in = h;
    repeat (3) @(negedge clk);
    step_in = 1'b0;
    if (!inhibit) begin
      amt = (h && (exp_pos % 2 == 0)) ? 2 : 1;
      exp_pos = d ? (exp_pos + amt) % 8 : (exp_pos + 8 - amt) % 8;
    end
    repeat (8) @(negedge clk);
    check_state({tag, " R1 fall"});
    new_d = delivered(inhibit, exp_pos);
    check({tag, " R9 kick A"}, kick_a_cnt - a0,
          int'(new_d[3:2] != old_d[3:2] && new_d[3:2] != 2'b00));
    check({tag, " R9 kick B"}, kick_b_cnt - b0,
          int'(new_d[1:0] != old_d[1:0] && new_d[1:0] != 2'b00));
    step_in = 1'b1;
    repeat (5) @(negedge clk);
    check_state({tag, " R1 rising edge no move"});
  endtask

  task automatic t_reset();
    int a0, b0;
    repeat (5) @(negedge clk);
    check("R7 outputs off in reset",
          int'({a_win1, a_win2, b_win1, b_win2, a_zero, b_zero, a_kick, b_kick}), 0);
    a0 = kick_a_cnt; b0 = kick_b_cnt;
    rst = 1'b0;
    exp_pos = 0;
    repeat (5) @(negedge clk);
    check_state("R7 home");
    check("R7 R9 kick A after reset", kick_a_cnt - a0, 1);
    check("R7 R9 kick B after reset", kick_b_cnt - b0, 1);
  endtask

  task automatic t_half_walk();
    for (int i = 0; i < 9; i++) do_step("R3 R5 half up", 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) do_step("R3 R5 half down", 1'b0, 1'b0);
  endtask

  task automatic t_full_walk();
    for (int i = 0; i < 3; i++) do_step("R3 full up", 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) do_step("R3 full down", 1'b0, 1'b1);
  endtask

  task automatic t_odd_full();
    do_step("R4 prep half up", 1'b1, 1'b0);
    do_step("R4 full up from odd", 1'b1, 1'b1);
    check("R4 landed up", exp_pos, 2);
    do_step("R4 prep half up", 1'b1, 1'b0);
    do_step("R4 full down from odd", 1'b0, 1'b1);
    check("R4 landed down", exp_pos, 2);
    do_step("R4 prep half down", 1'b0, 1'b0);
    do_step("R4 full down from odd", 1'b0, 1'b1);
  endtask

  task automatic t_hold_inputs();
    int a0, b0;
    a0 = kick_a_cnt; b0 = kick_b_cnt;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); dir_in = ~dir_in;
      repeat (2) @(negedge clk); half_n_in = ~half_n_in;
    end
    repeat (6) @(negedge clk);
    check_state("R2 no step edge");
    check("R2 no kick A", kick_a_cnt - a0, 0);
    check("R2 no kick B", kick_b_cnt - b0, 0);
  endtask

  task automatic t_inhibit();
    int a0, b0;
    do_step("R6 prep", 1'b1, 1'b0);
    a0 = kick_a_cnt; b0 = kick_b_cnt;
    @(negedge clk); inhibit = 1'b1;
    repeat (3) @(negedge clk);
    check_state("R6 R8 inhibited");
    check("R6 no kick on inhibit", kick_a_cnt + kick_b_cnt - a0 - b0, 0);
    do_step("R6 step while inhibited", 1'b1, 1'b0);
    a0 = kick_a_cnt; b0 = kick_b_cnt;
    @(negedge clk); inhibit = 1'b0;
    repeat (4) @(negedge clk);
    check_state("R6 released keeps position");
    check("R6 R9 kick A on release", kick_a_cnt - a0, 0);
    check("R6 R9 kick B on release", kick_b_cnt - b0, 1);
    do_step("R6 step after release", 1'b1, 1'b0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_half_walk();
    t_full_walk();
    t_odd_full();
    t_hold_inputs();
    t_inhibit();
    summary();
    $finish;
  end
endmodule